// File: doc/BRIEF.md
# Triggered Single-Bit Fault Injector

This block sits inline on a wide data path inside a design under test and deliberately corrupts it for fault-attack experiments. It watches a group of observed signals and compares each one with a target value held in its configuration. When every observed signal matches its target in the same cycle, the armed injector fires. It XORs a one-hot mask into the passing data word for a programmed number of cycles. Outside those cycles the word passes straight through, with no register stage.

The configuration holds one target value per observed signal. It also holds a table of fault entries, each made of a bit index and a duration. Each firing uses the next entry, so running the same workload once per entry flips a different bit each time. A typical setup watches a 4-bit round counter for the value 9 together with its 1-bit write enable. Entry k flips bit k, so that 128 runs sweep every bit of a 128-bit state once. The configuration is shifted in serially before the runs. A run-start pulse arms the injector for one firing, and a done flag reports that the table is used up.

Top module: `trig_flip_injector`

## Requirements
- R1: While the injector is not firing, `data_o` equals `data_i` in the same cycle.
- R2: The trigger matches only when every observed 4-bit field of `obs_i` equals its configured target. A mismatch in any one field keeps the data unchanged.
- R3: On the cycle the armed trigger matches, `data_o = data_i ^ (1 << idx)`, where idx is the bit index of the current entry. The change is combinational in that same cycle.
- R4: The mask stays applied for the entry's duration d, counted in consecutive cycles that begin with the trigger cycle. The observed signals have no effect once firing has begun. A duration of 0 acts as 1.
- R5: A run-start pulse arms the injector for exactly one firing. Matches after that firing has finished are ignored until the next run-start. A run-start that arrives while firing has no effect.
- R6: Entries are used in increasing order (0, 1, 2, ...), one entry per firing.
- R7: When the firing that uses the last entry ends, `done_o` goes high and stays high. From then on no bit is flipped, and the pointer does not wrap around.
- R8: While `scan_en` is high, the configuration shifts by one bit per clock. `scan_in` enters at bit 0 and `scan_out` is the top bit, so the first bit shifted in ends up as the top bit. The layout from the top down is: target of field NUM_OBS-1, down to target of field 0 (4 bits each), then entry N-1 down to entry 0. Each entry is {index[6:0], duration[3:0]}.
- R9: While `scan_en` is high, the trigger is suppressed and the data passes unchanged. An armed injector stays armed.
- R10: A low `rst_n` acts at once, asynchronously. It removes any mask in progress, drops `done_o`, returns the pointer to entry 0 and leaves the injector unarmed. The configuration is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; assertion is asynchronous and release is synchronised |
| run_start | input | 1 | One-cycle pulse that arms the injector for one firing |
| obs_i | input | NUM_OBS*OBS_W (8) | Observed signals; field j is bits [4j+3:4j] |
| scan_en | input | 1 | Shift enable for the configuration chain |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output (top bit of the chain) |
| data_i | input | DATA_W (128) | Data path input |
| data_o | output | DATA_W (128) | Data path output, with the mask applied while firing |
| done_o | output | 1 | All entries have been used |

## Verification
Each run is driven with observed values that miss the trigger by one field, first the round only and then the enable only, followed by a full match. This shows that a single mismatched field is enough to suppress injection. After the full match, the observed values are moved away while firing continues, and a second match is sent. This separates duration timing from trigger level and shows one-shot arming. Three entries have distinct durations (1, 3 and 0), which separates the counter behaviour from simple one-cycle pulsing.

A second configuration load is made while the injector is armed and the trigger matches. It checks that shifting blocks injection and that `scan_out` returns the previous image bit for bit. Resets are applied after exhaustion and in the middle of a multi-cycle fault, which shows that the pointer restarts and that a pending mask is dropped.

// File: rtl/tfi_pkg.sv
package tfi_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_FIRE  = 2'd2,
    S_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tfi_scan_cfg.sv
module tfi_scan_cfg #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           scan_en,
  input  logic           scan_in,
  output logic           scan_out,
  output logic [LEN-1:0] cfg_o
);
  logic [LEN-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = {cfg_q[LEN-2:0], scan_in};
  end

  // Configuration flops carry no reset so a reset leaves the loaded image intact.
  always_ff @(posedge clk) begin
    if (scan_en) cfg_q <= cfg_d;
  end

  assign scan_out = cfg_q[LEN-1];
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/tfi_trigger.sv
module tfi_trigger #(
  parameter int NUM_OBS = 2,
  parameter int OBS_W   = 4
) (
  input  logic [NUM_OBS*OBS_W-1:0] obs_i,
  input  logic [NUM_OBS*OBS_W-1:0] target_i,
  output logic                     match_o
);
  logic [NUM_OBS-1:0] eq;

  for (genvar j = 0; j < NUM_OBS; j++) begin : g_cmp
    assign eq[j] = (obs_i[j*OBS_W +: OBS_W] == target_i[j*OBS_W +: OBS_W]);
  end

  assign match_o = &eq;
endmodule

// File: rtl/tfi_sequencer.sv
module tfi_sequencer
  import tfi_pkg::*;
#(
  parameter int N_ENTRIES = 128,
  parameter int IDX_W     = 7,
  parameter int DUR_W     = 4,
  localparam int ENT_W    = IDX_W + DUR_W,
  localparam int PTR_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_start,
  input  logic                       trig,
  input  logic                       scan_en,
  input  logic [N_ENTRIES*ENT_W-1:0] entries_i,
  output logic                       fire_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic                       done_o
);
  seq_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             ptr_en, cnt_en;
  logic [ENT_W-1:0] cur;
  logic [DUR_W-1:0] cur_dur, eff_dur;
  logic             last, hit, finish;

  assign cur     = entries_i[ptr_q*ENT_W +: ENT_W];
  assign idx_o   = cur[ENT_W-1 -: IDX_W];
  assign cur_dur = cur[DUR_W-1:0];
  assign eff_dur = (cur_dur == '0) ? DUR_W'(1) : cur_dur;
  assign last    = (ptr_q == PTR_W'(N_ENTRIES - 1));
  assign hit     = (state_q == S_ARMED) && trig && !scan_en;
  assign fire_o  = hit || (state_q == S_FIRE);
  assign done_o  = (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      S_IDLE:  if (run_start) state_d = S_ARMED;
      S_ARMED: if (hit) begin
        if (eff_dur == DUR_W'(1)) finish = 1'b1;
        else begin
          state_d = S_FIRE;
          cnt_d   = eff_dur - DUR_W'(1);
          cnt_en  = 1'b1;
        end
      end
      S_FIRE: begin
        if (cnt_q == DUR_W'(1)) finish = 1'b1;
        else begin
          cnt_d  = cnt_q - DUR_W'(1);
          cnt_en = 1'b1;
        end
      end
      S_DONE:  state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
    if (finish) state_d = last ? S_DONE : S_IDLE;
    ptr_en = finish && !last;
    ptr_d  = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> (ptr_q == $past(ptr_q) + PTR_W'(1)));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE) |=> (state_q == S_DONE));
  assert_done_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(fire_o));
  assert_fire_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FIRE) |-> (cnt_q != '0));
endmodule

// File: rtl/tfi_mask.sv
module tfi_mask #(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 7
) (
  input  logic              fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] mask;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign mask[b] = fire && (idx == IDX_W'(b));
  end

  assign data_o = data_i ^ mask;
endmodule

// File: rtl/trig_flip_injector.sv
module trig_flip_injector #(
  parameter int DATA_W    = 128,
  parameter int N_ENTRIES = 128,
  parameter int DUR_W     = 4,
  parameter int NUM_OBS   = 2,
  parameter int OBS_W     = 4,
  localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int ENT_W    = IDX_W + DUR_W,
  localparam int TAB_W    = N_ENTRIES * ENT_W,
  localparam int TGT_W    = NUM_OBS * OBS_W,
  localparam int SCAN_LEN = TAB_W + TGT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic [TGT_W-1:0]  obs_i,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [SCAN_LEN-1:0] cfg;
  logic                trig, fire;
  logic [IDX_W-1:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1] && rst_n;

  tfi_scan_cfg #(.LEN(SCAN_LEN)) u_cfg (
    .clk(clk), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .cfg_o(cfg)
  );

  tfi_trigger #(.NUM_OBS(NUM_OBS), .OBS_W(OBS_W)) u_trig (
    .obs_i(obs_i), .target_i(cfg[SCAN_LEN-1 -: TGT_W]), .match_o(trig)
  );

  tfi_sequencer #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .DUR_W(DUR_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .run_start(run_start), .trig(trig),
    .scan_en(scan_en), .entries_i(cfg[TAB_W-1:0]),
    .fire_o(fire), .idx_o(idx), .done_o(done_o)
  );

  tfi_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .fire(fire), .idx(idx), .data_i(data_i), .data_o(data_o)
  );

  assert_pass_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fire |-> (data_o == data_i));
  assert_single_bit_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(data_o ^ data_i));
  assert_scan_quiet_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    scan_en |-> (data_o == data_i));
  assert_mismatch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!trig && !$past(fire)) |-> (data_o == data_i));
endmodule

// File: tb/sim_trig_flip_injector.sv
module sim_trig_flip_injector;
  localparam int DW   = 128;
  localparam int NE   = 128;
  localparam int EW   = 11;
  localparam int TABW = NE * EW;
  localparam int SL   = TABW + 8;

  typedef struct {
    logic [DW-1:0] d;
    logic          chk_so;
    logic          so;
    logic          dn;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          run_start = 1'b0;
  logic [7:0]    obs_i = '0;
  logic          scan_en = 1'b0, scan_in = 1'b0;
  logic          scan_out;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          done_o;

  exp_t      q[$];
  int        checks = 0, failures = 0;
  logic      exp_done = 1'b0;
  logic [SL-1:0] img;
  bit        finished = 1'b0;

  always #2.5 clk = ~clk;

  trig_flip_injector u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .obs_i(obs_i),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .data_i(data_i), .data_o(data_o), .done_o(done_o)
  );

  function automatic int dur_of(input int k);
    if (k == 1) return 3;
    if (k == 2) return 0;
    return 1;
  endfunction

  function automatic int eff_of(input int k);
    return (dur_of(k) == 0) ? 1 : dur_of(k);
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input logic rs, input logic [3:0] rnd, input logic we,
                      input logic se, input logic si, input logic chk_so,
                      input logic exp_so, input int flip, input string tag);
    exp_t e;
    data_i    = {$urandom, $urandom, $urandom, $urandom};
    run_start = rs;
    obs_i     = {3'b000, we, rnd};
    scan_en   = se;
    scan_in   = si;
    e.d       = (flip >= 0) ? (data_i ^ (128'd1 << flip)) : data_i;
    e.chk_so  = chk_so;
    e.so      = exp_so;
    e.dn      = exp_done;
    e.tag     = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic chk, input logic [3:0] rnd, input logic we, input string tag);
    for (int i = 0; i < SL; i++)
      step(1'b0, rnd, we, 1'b1, img[SL-1-i], chk, img[SL-1-i], -1, tag);
    scan_en = 1'b0;
  endtask

  // Monitor: compares outputs against the queued expectations.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (data_o !== e.d) begin
          failures++;
          $display("FAIL %s data_o act=%h exp=%h", e.tag, data_o, e.d);
        end
        checks++;
        if (done_o !== e.dn) begin
          failures++;
          $display("FAIL %s done_o act=%b exp=%b", e.tag, done_o, e.dn);
        end
        if (e.chk_so) begin
          checks++;
          if (scan_out !== e.so) begin
            failures++;
            $display("FAIL %s scan_out act=%b exp=%b", e.tag, scan_out, e.so);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NE; k++) img[k*EW +: EW] = {7'(k), 4'(dur_of(k))};
    img[TABW +: 4]     = 4'd9;
    img[TABW + 4 +: 4] = 4'd1;

    #1 rst_n = 1'b0;
    @(negedge clk);
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R10 reset state");
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R10 reset state");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R1 idle");

    load_cfg(1'b0, 4'd0, 1'b0, "R8 first load");
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R10 unarmed after reset");
    step(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R5 arm");
    // Reload the same image while armed with the trigger matching.
    load_cfg(1'b1, 4'd9, 1'b1, "R8 R9 reload");

    for (int k = 0; k < NE; k++) begin
      if (k > 0) step(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R5 arm");
      step(1'b0, 4'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R2 round mismatch");
      step(1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R2 enable mismatch");
      for (int j = 0; j < eff_of(k); j++) begin
        if (j == 0) step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, k, "R3 R6 flip");
        else step((k == 1 && j == 1), 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, k, "R4 duration");
      end
      if (k == NE - 1) exp_done = 1'b1;
      step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R5 one shot");
    end

    step(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R7 done");
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R7 no wrap");

    rst_n = 1'b0;
    exp_done = 1'b0;
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R10 reset clears done");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R1 idle");
    step(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R5 arm");
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10 pointer restart");
    step(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R5 arm");
    step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R6 second entry");
    rst_n = 1'b0;
    step(1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R10 pending mask dropped");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R10 unarmed");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule